// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block makes the serial clock for the master side of a synchronous serial port. It divides the system clock in two cascaded stages. The first stage is an even prescaler. The second stage is a post-divider that divides by one plus an 8-bit control value. The serial clock period is the prescale value times (1 + post-divide value) system clocks. Its high and low halves are equal, so the duty cycle is exactly 50%.

Two configuration registers are written through a one-cycle write strobe with a single address bit. A written value first goes into a shadow copy. It moves to the active copy only while the block is disabled or at a half-period boundary. Because of this, a reconfiguration never cuts a half-period short. Alongside the clock, the block gives a one-cycle sample strobe in the first system cycle after each rising edge and a one-cycle shift strobe in the first system cycle after each falling edge, ready for a serial shifter. A status output warns when the programmed ratio is too small for a peer that recovers the clock by oversampling.

Top module: `sclk_rate_gen`

## Requirements
- R1: While enabled, the serial clock period is P*(1+D) system clocks and each half lasts P*(1+D)/2 clocks. P is the active prescale value and D is the active post-divide value.
- R2: A write to address 0 stores the prescale with bit 0 forced to zero. A result of zero is stored as 2, so a write of 7 acts as 6 and a write of 0 or 1 acts as 2.
- R3: A write to address 1 stores an 8-bit post-divide value D. Every D from 0 to 255 gives a second-stage ratio of 1+D, so D=0 with P=2 gives a period of 2 and D=255 with P=254 gives a period of 65024.
- R4: While en is low, sclk, shift_stb and sample_stb are held low, and the configuration is taken over at once.
- R5: If en is first sampled high at a clock edge, sclk rises at the edge that is exactly P*(1+D)/2 system clocks later (counting that first edge as one).
- R6: sample_stb is high for exactly the first system cycle in which sclk is high after a rising edge, and is low at all other times.
- R7: shift_stb is high for exactly the first system cycle in which sclk is low after a falling edge caused by division, and is low at all other times.
- R8: slow_ratio is high exactly when the programmed prescale times (1 + programmed post-divide) is below 12. It follows a write on the next edge.
- R9: A configuration written while enabled leaves the current half-period at its old length. The new values govern every half-period that starts after the next boundary.
- R10: After reset the prescale is 2 and the post-divide is 0. sclk and both strobes are low, and slow_ratio is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable for the divider |
| cfg_we | input | 1 | One-cycle configuration write strobe |
| cfg_addr | input | 1 | 0 selects the prescale, 1 selects the post-divide |
| cfg_wdata | input | CFG_W | Write data |
| sclk | output | 1 | Serial clock output |
| shift_stb | output | 1 | One-cycle strobe after each falling edge |
| sample_stb | output | 1 | One-cycle strobe after each rising edge |
| slow_ratio | output | 1 | Programmed total ratio below 12 |

## Verification
The bench builds the block with the default CFG_W of 8. At that width both ends of each field can be reached: a prescale of 2 and 254, and a post-divide of 0 and 255. This covers the smallest period of 2 clocks and the largest period of 65024 clocks, including the first-edge delay and one full period at the largest setting. Random settings with small ratios cover the region around the threshold of 12 for slow_ratio. Directed cases cover odd and zero prescale writes, a write in the middle of a half-period, and disabling while sclk is high.

// File: rtl/sclk_rate_pkg.sv
package sclk_rate_pkg;
  parameter int unsigned DFLT_CFG_W = 8;
  parameter int unsigned SLOW_LIMIT = 12;

  typedef enum logic {
    SEL_PRESCALE = 1'b0,
    SEL_POSTDIV  = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/sclk_cfg_regs.sv
module sclk_cfg_regs
  import sclk_rate_pkg::*;
#(
  parameter int unsigned CFG_W = DFLT_CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             boundary,
  input  logic             we,
  input  logic             addr,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] shd_pre,
  output logic [CFG_W-1:0] shd_div,
  output logic [CFG_W-1:0] act_pre,
  output logic [CFG_W-1:0] act_div
);
  localparam logic [CFG_W-1:0] PRE_MIN = CFG_W'(2);

  // Clear the low bit; a zero result becomes the smallest legal value
  function automatic logic [CFG_W-1:0] fix_pre(input logic [CFG_W-1:0] raw);
    logic [CFG_W-1:0] v;
    v = {raw[CFG_W-1:1], 1'b0};
    if (v == '0) v = PRE_MIN;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_pre <= PRE_MIN;
      shd_div <= '0;
      act_pre <= PRE_MIN;
      act_div <= '0;
    end else begin
      if (we) begin
        if (cfg_sel_e'(addr) == SEL_PRESCALE) shd_pre <= fix_pre(wdata);
        else                                  shd_div <= wdata;
      end
      if (!en || boundary) begin
        act_pre <= shd_pre;
        act_div <= shd_div;
      end
    end
  end
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
  import sclk_rate_pkg::*;
#(
  parameter int unsigned CFG_W = DFLT_CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CFG_W-1:0] pre,
  output logic             tick
);
  localparam int unsigned HW = CFG_W - 1;
  localparam logic [HW-1:0] ONE_H = HW'(1);

  logic [HW-1:0] half;
  logic [HW-1:0] cnt;

  // One tick per half of the prescale value: two ticks per prescale span
  assign half = pre[CFG_W-1:1];
  assign tick = en && (cnt == half - ONE_H);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + ONE_H;
  end
endmodule

// File: rtl/sclk_postdiv.sv
module sclk_postdiv
  import sclk_rate_pkg::*;
#(
  parameter int unsigned CFG_W = DFLT_CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CFG_W-1:0] div,
  output logic             boundary
);
  localparam logic [CFG_W-1:0] ONE_D = CFG_W'(1);

  logic [CFG_W-1:0] cnt;

  assign boundary = tick && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!en)      cnt <= '0;
    else if (boundary) cnt <= '0;
    else if (tick)     cnt <= cnt + ONE_D;
  end
endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
  import sclk_rate_pkg::*;
#(
  parameter int unsigned CFG_W = DFLT_CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             sclk,
  output logic             shift_stb,
  output logic             sample_stb,
  output logic             slow_ratio
);
  localparam int unsigned RATIO_W = 2 * CFG_W + 1;
  localparam logic [RATIO_W-1:0] SLOW_R = RATIO_W'(SLOW_LIMIT);

  function automatic logic [RATIO_W-1:0] total_ratio(input logic [CFG_W-1:0] p,
                                                     input logic [CFG_W-1:0] d);
    logic [RATIO_W-1:0] a, b;
    a = RATIO_W'(p);
    b = RATIO_W'(d) + RATIO_W'(1);
    return a * b;
  endfunction

  logic [CFG_W-1:0] shd_pre, shd_div, act_pre, act_div;
  logic             pre_tick;
  logic             boundary;

  sclk_cfg_regs #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en(en), .boundary(boundary),
    .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .shd_pre(shd_pre), .shd_div(shd_div), .act_pre(act_pre), .act_div(act_div)
  );

  sclk_prescaler #(.CFG_W(CFG_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .pre(act_pre), .tick(pre_tick)
  );

  sclk_postdiv #(.CFG_W(CFG_W)) u_post (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(pre_tick), .div(act_div),
    .boundary(boundary)
  );

  assign slow_ratio = total_ratio(shd_pre, shd_div) < SLOW_R;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk       <= 1'b0;
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end else if (!en) begin
      sclk       <= 1'b0;
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end else if (boundary) begin
      sclk       <= ~sclk;
      sample_stb <= ~sclk;
      shift_stb  <= sclk;
    end else begin
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/sclk_rate_chk.sv
module sclk_rate_chk #(
  parameter int unsigned CFG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             sclk,
  input logic             shift_stb,
  input logic             sample_stb,
  input logic             boundary,
  input logic [CFG_W-1:0] act_pre,
  input logic [CFG_W-1:0] act_div
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sclk && !shift_stb && !sample_stb)); // R4
  AST_PRE_EVEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pre[0] == 1'b0) && (act_pre != '0)); // R2
  AST_RISE_HAS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> sample_stb); // R6
  AST_SAMPLE_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (sclk && !$past(sclk))); // R6
  AST_FALL_HAS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && $past(en)) |-> shift_stb); // R7
  AST_SHIFT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> (!sclk && $past(sclk))); // R7
  AST_CFG_HELD_MID_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(boundary)) |-> ($stable(act_pre) && $stable(act_div))); // R9
  AST_EDGE_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(boundary)) |-> $stable(sclk)); // R1
endmodule

bind sclk_rate_gen sclk_rate_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sclk(sclk), .shift_stb(shift_stb),
  .sample_stb(sample_stb), .boundary(boundary), .act_pre(act_pre), .act_div(act_div)
);

// File: tb/sclk_rate_gen_test.sv
module sclk_rate_gen_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         cfg_we = 1'b0;
  logic         cfg_addr = 1'b0;
  logic [W-1:0] cfg_wdata = '0;
  logic         sclk, shift_stb, sample_stb, slow_ratio;

  int checks = 0;
  int errors = 0;

  sclk_rate_gen #(.CFG_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sclk(sclk), .shift_stb(shift_stb),
    .sample_stb(sample_stb), .slow_ratio(slow_ratio)
  );

  always #5 clk = ~clk;

  function automatic int legal_pre(input int raw);
    int v;
    v = raw & 32'hFE;
    return (v == 0) ? 2 : v;
  endfunction

  function automatic int period_of(input int p, input int d);
    return p * (d + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = W'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Program while idle, enable, and time the first rise, the fall and the next rise
  task automatic run_case(input int pre_raw, input int d);
    int p, per, h, rise1, fall1, rise2, bad;
    bit prev;
    p = legal_pre(pre_raw);
    per = period_of(p, d);
    h = per / 2;
    wr(1'b0, pre_raw);
    wr(1'b1, d);
    @(negedge clk);
    check(slow_ratio == (per < 12), "R8 slow flag", slow_ratio, per < 12);
    en = 1'b1;
    rise1 = -1; fall1 = -1; rise2 = -1; bad = 0; prev = 1'b0;
    for (int n = 1; n <= 3 * h + 2 && rise2 < 0; n++) begin
      @(negedge clk);
      if (sample_stb != (sclk && !prev)) bad++;
      if (shift_stb != (!sclk && prev)) bad++;
      if (sclk && !prev) begin
        if (rise1 < 0) rise1 = n; else rise2 = n;
      end
      if (!sclk && prev && fall1 < 0) fall1 = n;
      prev = sclk;
    end
    check(rise1 == h, "R5 first rise", rise1, h);
    check(fall1 - rise1 == h, "R1 high half", fall1 - rise1, h);
    check(rise2 - rise1 == per, "R1 R3 period", rise2 - rise1, per);
    check(bad == 0, "R6 R7 strobes", bad, 0);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int rise, fall, bad;
    bit prev;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(sclk == 1'b0, "R10 sclk", sclk, 0);
    check(shift_stb == 1'b0 && sample_stb == 1'b0, "R10 strobes", shift_stb | sample_stb, 0);
    check(slow_ratio == 1'b1, "R10 slow flag", slow_ratio, 1);
    // R10 default ratio 2: sclk toggles every system clock
    en = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R10 default rise", sclk, 1);
    @(negedge clk);
    check(sclk == 1'b0, "R10 default fall", sclk, 0);
    en = 1'b0;
    @(negedge clk);

    // Directed corners
    run_case(2, 0);      // R3 smallest
    run_case(254, 0);
    run_case(2, 255);
    run_case(7, 1);      // R2 odd write acts as 6
    run_case(0, 2);      // R2 zero write acts as 2
    run_case(1, 3);      // R2 one acts as 2
    run_case(2, 4);      // R8 ratio 10
    run_case(2, 5);      // R8 ratio 12
    run_case(12, 0);     // R8 ratio 12
    run_case(10, 0);     // R8 ratio 10
    for (int i = 0; i < 10; i++) begin
      int rp, rd;
      rp = int'($urandom_range(0, 24));
      rd = int'($urandom_range(0, 15));
      run_case(rp, rd);
    end
    run_case(254, 255);  // R3 largest

    // R9: write mid-half; current half keeps old length
    wr(1'b0, 4);
    wr(1'b1, 1);
    @(negedge clk);
    en = 1'b1;
    rise = -1; fall = -1; prev = 1'b0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (n == 1) begin cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = W'(3); end
      if (n == 2) cfg_we = 1'b0;
      if (sclk && !prev && rise < 0) rise = n;
      if (!sclk && prev && fall < 0) fall = n;
      prev = sclk;
    end
    check(rise == 4, "R9 old half kept", rise, 4);
    check(fall == 12, "R9 new half used", fall, 12);

    // R4: disable while sclk is high
    for (int n = 0; n < 40 && !sample_stb; n++) @(negedge clk);
    check(sclk == 1'b1, "R4 setup high", sclk, 1);
    en = 1'b0;
    bad = 0;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (sclk || shift_stb || sample_stb) bad++;
    end
    check(bad == 0, "R4 idle quiet", bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule